// File: doc/BRIEF.md
# Two-Level Rotating Priority Interrupt Arbiter

This block picks one winner among up to 32 interrupt request lines and reports it as a source number with a valid flag. The requests are split across six first-level arbiters of six inputs each. A second-level arbiter then chooses among the first-level arbiters that have a request. In every one of the seven arbiters, input 0 always comes first and input 5 always comes last. The order of inputs 1 to 4 is set by a two-bit selector.

Each arbiter also has a mode bit. In fixed mode the selector only changes when software writes it. In rotating mode, accepting a grant moves the input that was just served to the last place among inputs 1 to 4. The grant is combinational from the current requests and selectors. The interrupt handler accepts it with a one-cycle strobe. Software writes and reads the selectors and mode bits through a single configuration word.

Top module: `irq_rot_arb`

## Requirements
- R1: Source n is wired to first-level arbiter n/6, input n%6. The unused inputs of the last arbiter are inactive. `grant_idx` gives the winning source number n.
- R2: In every arbiter, a request on input 0 wins over all other inputs, and input 5 wins only when inputs 0 to 4 are idle. This holds for every selector value. The second-level arbiter ranks first-level arbiter k as its input k.
- R3: For inputs 1 to 4, selector 0 gives the order 1,2,3,4. Selector 1 gives 2,3,4,1. Selector 2 gives 3,4,1,2. Selector 3 gives 4,1,2,3.
- R4: In rotating mode, an accepted grant to input 1, 2, 3 or 4 sets that arbiter's selector to 1, 2, 3 or 0 respectively.
- R5: An accepted grant to input 0 or input 5 leaves the selector unchanged.
- R6: With the mode bit at 0, the selector keeps its written value across accepted grants.
- R7: An accepted grant updates only the second-level arbiter and the first-level arbiter that won. All other selectors stay unchanged.
- R8: A grant is accepted only in a cycle where `grant_ack` is high and `grant_vld` is high. Otherwise no selector changes.
- R9: Configuration bits [3k+1:3k] hold arbiter k's selector and bit 3k+2 holds its mode (1 = rotating). Arbiter 6 is the second level. A write shows on `cfg_rdata` one cycle later. A write in the same cycle as an accepted grant takes precedence. The reset value is all zeros.
- R10: `grant_vld` is low when no request is active. `grant_idx` and `grant_vld` follow the requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_REQ | Interrupt request lines |
| grant_ack | input | 1 | Strobe accepting the current grant |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 3*(NUM_L1+1) | Configuration write value |
| cfg_rdata | output | 3*(NUM_L1+1) | Current configuration (modes and selectors) |
| grant_idx | output | $clog2(NUM_REQ) | Winning source number |
| grant_vld | output | 1 | A request is active and `grant_idx` is meaningful |

## Verification
The bench builds the block with the default of 32 sources. With that setting all six first-level arbiters and every second-level input are in use. The last first-level arbiter has only two real inputs, so sources 30 and 31 check the tie-off of its spare inputs. The bench walks one arbiter through all four selector orders and a complete rotation cycle. It also sets every arbiter to rotating mode, which shows that an accepted grant touches only the winning path.

// File: rtl/irq_arb_pkg.sv
// Shared constants and helpers for the two-level rotating arbiter.
// Assumes every arbiter has exactly six inputs, of which inputs 1..4 rotate.
package irq_arb_pkg;
    localparam int ARB_IN  = 6;   // inputs per arbiter
    localparam int SEL_W   = 2;   // selector width
    localparam int FIELD_W = 3;   // selector plus mode bit per arbiter
    localparam int POS_W   = 3;   // width of an input position

    // Selector after a grant to position won: 1->1, 2->2, 3->3, 4->0, 0/5 keep.
    function automatic logic [SEL_W-1:0] rot_next(input logic [SEL_W-1:0] cur,
                                                  input logic [POS_W-1:0] won);
        if (won >= 3'd1 && won <= 3'd4)
            return won[SEL_W-1:0];
        return cur;
    endfunction
endpackage

// File: rtl/irq_arb_cell.sv
// One six-input arbiter. Input 0 is always first and input 5 always last.
// Inputs 1..4 are visited starting at input sel+1 and wrapping within 1..4.
// The cell is purely combinational and holds no state.
module irq_arb_cell
    import irq_arb_pkg::*;
(
    input  logic [ARB_IN-1:0] req,
    input  logic [SEL_W-1:0]  sel,
    output logic              vld,
    output logic [POS_W-1:0]  pos
);
    // Pick the highest ranked active input under the current selector.
    always_comb begin
        logic             found;
        logic [SEL_W-1:0] off;
        logic [POS_W-1:0] cand;
        found = 1'b0;
        pos   = '0;
        off   = '0;
        cand  = '0;
        if (req[0]) begin
            found = 1'b1;
        end
        for (int k = 0; k < 4; k++) begin
            off  = sel + SEL_W'(k);
            cand = {1'b0, off} + 3'd1;
            if (!found && req[cand]) begin
                found = 1'b1;
                pos   = cand;
            end
        end
        if (!found && req[5]) begin
            pos = 3'd5;
        end
    end

    // Any active input makes the cell valid.
    assign vld = |req;
endmodule

// File: rtl/irq_arb_cfg.sv
// Holds the mode bit and selector of every arbiter.
// A software write has precedence over selector updates from accepted grants.
// Assumes that upd_en is raised only for arbiters in rotating mode.
module irq_arb_cfg
    import irq_arb_pkg::*;
#(
    parameter int NUM_ARB = 7,
    localparam int CFG_BITS = FIELD_W * NUM_ARB
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_BITS-1:0]      cfg_wdata,
    input  logic [NUM_ARB-1:0]       upd_en,
    input  logic [NUM_ARB*SEL_W-1:0] upd_sel,
    output logic [CFG_BITS-1:0]      cfg_q
);
    // Configuration register: reset, software write, or per-arbiter rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end else begin
            for (int k = 0; k < NUM_ARB; k++) begin
                if (upd_en[k])
                    cfg_q[FIELD_W*k +: SEL_W] <= upd_sel[SEL_W*k +: SEL_W];
            end
        end
    end

    // Fixed-mode selectors never move on their own.
    for (genvar g = 0; g < NUM_ARB; g++) begin : g_chk
        AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_we && !cfg_q[FIELD_W*g+2]) |=> $stable(cfg_q[FIELD_W*g +: SEL_W])); // R6
    end
endmodule

// File: rtl/irq_rot_arb.sv
// Two-level rotating priority arbiter for NUM_REQ interrupt requests.
// The first level has NUM_L1 six-input cells and the second level has one cell.
// On an accepted grant, the rotating cells on the winning path update their selectors.
// Assumes NUM_REQ is at most 36 so that the second level has enough inputs.
module irq_rot_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_REQ = 32,
    localparam int NUM_L1   = (NUM_REQ + ARB_IN - 1) / ARB_IN,
    localparam int NUM_ARB  = NUM_L1 + 1,
    localparam int L2_ID    = NUM_L1,
    localparam int CFG_BITS = FIELD_W * NUM_ARB,
    localparam int IDX_W    = $clog2(NUM_REQ),
    localparam int PAD_W    = NUM_L1 * ARB_IN
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REQ-1:0]  req,
    input  logic                grant_ack,
    input  logic                cfg_we,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    output logic [CFG_BITS-1:0] cfg_rdata,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                grant_vld
);
    logic [PAD_W-1:0]         req_pad;
    logic [NUM_L1-1:0]        l1_vld;
    logic [POS_W-1:0]         l1_pos [NUM_L1];
    logic [ARB_IN-1:0]        l2_req;
    logic                     l2_vld;
    logic [POS_W-1:0]         l2_pos;
    logic [POS_W-1:0]         win_pos;
    logic [NUM_ARB-1:0]       upd_en;
    logic [NUM_ARB*SEL_W-1:0] upd_sel;
    logic                     accept;

    // Spare first-level inputs are tied inactive.
    always_comb begin
        req_pad = '0;
        req_pad[NUM_REQ-1:0] = req;
    end

    // First-level cells, six requests each.
    for (genvar g = 0; g < NUM_L1; g++) begin : g_l1
        irq_arb_cell u_cell (
            .req (req_pad[ARB_IN*g +: ARB_IN]),
            .sel (cfg_rdata[FIELD_W*g +: SEL_W]),
            .vld (l1_vld[g]),
            .pos (l1_pos[g])
        );
    end

    // The second level sees each first-level cell's valid flag.
    always_comb begin
        l2_req = '0;
        l2_req[NUM_L1-1:0] = l1_vld;
    end

    irq_arb_cell u_l2 (
        .req (l2_req),
        .sel (cfg_rdata[FIELD_W*L2_ID +: SEL_W]),
        .vld (l2_vld),
        .pos (l2_pos)
    );

    // Select the position reported by the winning first-level cell.
    always_comb begin
        win_pos = '0;
        for (int k = 0; k < NUM_L1; k++) begin
            if (l2_pos == POS_W'(k))
                win_pos = l1_pos[k];
        end
    end

    // Form the global source number from the winning cell and its position.
    always_comb begin
        logic [IDX_W+3:0] full;
        full = (IDX_W+4)'(l2_pos) * (IDX_W+4)'(ARB_IN) + (IDX_W+4)'(win_pos);
        grant_idx = full[IDX_W-1:0];
    end

    assign grant_vld = l2_vld;
    assign accept    = grant_ack && grant_vld;

    // Rotation requests: the second level plus the first-level cell that won.
    always_comb begin
        upd_en  = '0;
        upd_sel = '0;
        for (int k = 0; k < NUM_L1; k++) begin
            upd_en[k] = accept && (l2_pos == POS_W'(k)) && cfg_rdata[FIELD_W*k+2];
            upd_sel[SEL_W*k +: SEL_W] = rot_next(cfg_rdata[FIELD_W*k +: SEL_W], l1_pos[k]);
        end
        upd_en[L2_ID] = accept && cfg_rdata[FIELD_W*L2_ID+2];
        upd_sel[SEL_W*L2_ID +: SEL_W] = rot_next(cfg_rdata[FIELD_W*L2_ID +: SEL_W], l2_pos);
    end

    irq_arb_cfg #(.NUM_ARB(NUM_ARB)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .upd_en    (upd_en),
        .upd_sel   (upd_sel),
        .cfg_q     (cfg_rdata)
    );

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> req[grant_idx]); // R1
    AST_SRC0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (grant_vld && grant_idx == '0)); // R2
    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> !grant_vld); // R10
    AST_NO_ACCEPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !(grant_ack && grant_vld)) |=> $stable(cfg_rdata)); // R8
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata == $past(cfg_wdata))); // R9
endmodule

// File: tb/irq_rot_arb_bench.sv
// Directed bench for irq_rot_arb; every scenario task checks its own results.
module irq_rot_arb_bench;
    localparam int NREQ = 32;
    localparam int CW   = 21;
    localparam int IW   = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREQ-1:0] req = '0;
    logic            grant_ack = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CW-1:0]   cfg_wdata = '0;
    logic [CW-1:0]   cfg_rdata;
    logic [IW-1:0]   grant_idx;
    logic            grant_vld;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_rot_arb #(.NUM_REQ(NREQ)) u_irq_rot_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .grant_ack(grant_ack),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .grant_idx(grant_idx), .grant_vld(grant_vld)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input logic [NREQ-1:0] v);
        @(negedge clk);
        req = v;
        #1;
    endtask

    task automatic wr_cfg(input logic [CW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        grant_ack = 1'b1;
        @(negedge clk);
        grant_ack = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        set_req('0);
        chk("R9 reset cfg", 32'(cfg_rdata), 0);
        chk("R10 idle vld", 32'(grant_vld), 0);
    endtask

    task automatic t_map();
        set_req(32'h1 << 7);  chk("R1 src7", 32'(grant_idx), 7);
        set_req(32'h1 << 17); chk("R1 src17", 32'(grant_idx), 17);
        set_req(32'h1 << 31); chk("R1 src31", 32'(grant_idx), 31);
        set_req(32'h1 << 30); chk("R1 src30 vld", 32'(grant_vld), 1);
        chk("R1 src30", 32'(grant_idx), 30);
    endtask

    task automatic t_fixed_prio();
        wr_cfg('0);
        set_req(32'h3E); chk("R2 in1 over 2..5", 32'(grant_idx), 1);
        set_req(32'h21); chk("R2 in0 over in5", 32'(grant_idx), 0);
        set_req(32'h2030); chk("R2 in4 over in5", 32'(grant_idx), 4);
        set_req((32'h1 << 6) | (32'h1 << 13)); chk("R2 l2 arb1 first", 32'(grant_idx), 6);
        set_req((32'h1 << 5) | (32'h1 << 6)); chk("R2 l2 arb0 first", 32'(grant_idx), 5);
    endtask

    task automatic t_sel_orders();
        for (int s = 0; s < 4; s++) begin
            wr_cfg(CW'(s));
            set_req(32'h1E);
            chk("R3 head of order", 32'(grant_idx), 32'(s + 1));
            set_req(32'h3F);
            chk("R2 in0 any sel", 32'(grant_idx), 0);
        end
        wr_cfg(CW'(2)); set_req(32'h6);  chk("R3 sel2 1 before 2", 32'(grant_idx), 1);
        wr_cfg(CW'(3)); set_req(32'hC);  chk("R3 sel3 2 before 3", 32'(grant_idx), 2);
        wr_cfg(CW'(1)); set_req(32'h22); chk("R2 sel1 in1 over in5", 32'(grant_idx), 1);
    endtask

    task automatic t_rotate();
        wr_cfg(CW'(3'b100));
        set_req(32'h1E);
        chk("R4 start", 32'(grant_idx), 1);
        pulse_ack(); chk("R4 after 1 sel", 32'(cfg_rdata[1:0]), 1);
        chk("R4 after 1 idx", 32'(grant_idx), 2);
        pulse_ack(); chk("R4 after 2 sel", 32'(cfg_rdata[1:0]), 2);
        pulse_ack(); chk("R4 after 3 sel", 32'(cfg_rdata[1:0]), 3);
        chk("R4 after 3 idx", 32'(grant_idx), 4);
        pulse_ack(); chk("R4 after 4 sel", 32'(cfg_rdata[1:0]), 0);
        chk("R4 wrap idx", 32'(grant_idx), 1);
    endtask

    task automatic t_edge_inputs();
        wr_cfg(CW'(3'b110));
        set_req(32'h1); pulse_ack();
        chk("R5 in0 keeps sel", 32'(cfg_rdata), 32'h6);
        set_req(32'h20); pulse_ack();
        chk("R5 in5 keeps sel", 32'(cfg_rdata), 32'h6);
    endtask

    task automatic t_fixed_mode();
        wr_cfg(CW'(3'b001));
        set_req(32'h1E);
        pulse_ack(); pulse_ack();
        chk("R6 sel kept", 32'(cfg_rdata), 1);
        chk("R6 idx kept", 32'(grant_idx), 2);
    endtask

    task automatic t_path_only();
        wr_cfg({7{3'b100}});
        set_req(32'h1 << 8);
        chk("R7 idx", 32'(grant_idx), 8);
        pulse_ack();
        chk("R7 only path moved", 32'(cfg_rdata),
            32'({3'b101, 3'b100, 3'b100, 3'b100, 3'b100, 3'b110, 3'b100}));
    endtask

    task automatic t_no_ack();
        wr_cfg(CW'(3'b100));
        set_req(32'h1E);
        repeat (3) @(negedge clk);
        chk("R8 no strobe", 32'(cfg_rdata), 32'h4);
        set_req('0);
        pulse_ack();
        chk("R8 strobe no vld", 32'(cfg_rdata), 32'h4);
        chk("R10 no req vld", 32'(grant_vld), 0);
    endtask

    task automatic t_cfg_wins();
        wr_cfg(CW'(3'b100));
        set_req(32'h2);
        @(negedge clk);
        grant_ack = 1'b1;
        cfg_we = 1'b1;
        cfg_wdata = CW'(3'b111);
        @(negedge clk);
        grant_ack = 1'b0;
        cfg_we = 1'b0;
        #1;
        chk("R9 write beats grant", 32'(cfg_rdata), 32'h7);
        chk("R10 same-cycle idx", 32'(grant_idx), 1);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_fixed_prio();
        t_sel_orders();
        t_rotate();
        t_edge_inputs();
        t_fixed_mode();
        t_path_only();
        t_no_ack();
        t_cfg_wins();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule